// File: doc/BRIEF.md
# CAN Bus Wake-Up Detector

This block sits beside a CAN transceiver's low-power receiver while the node sleeps. It watches the receiver's single output bit, where 0 means the bus is dominant and 1 means it is recessive. When the bus shows activity that qualifies as a wake request, it raises a wake pulse. The bit arrives asynchronously. A two-flop synchroniser brings it into the clock domain first, and every later decision uses the synchronised sample.

A parameter selects one of two wake methods. In basic mode, one dominant phase held for the filter time is enough. In pattern mode, three phases must follow in order: dominant, then recessive, then dominant. Each phase must last at least the filter time, and the whole sequence must finish inside a timeout window that starts on its first dominant sample. When a phase is too short, or the window runs out, the progress made so far is thrown away.

The filter time and the timeout are counted in clock cycles. By default the filter time is 3.6 µs divided by the clock period. The wake-enable input arms the detector. Once the detector has pulsed, it does nothing more until the enable is dropped and raised again.

Top module: `can_wake_detect`

## Requirements
- R1: During reset and after its release, `wake_pulse` is 0. The detector starts disarmed and takes one clock with `wake_en` high to arm.
- R2: Basic mode: FILTER_CYC consecutive dominant (0) input cycles produce a pulse. The pulse is first visible FILTER_CYC+2 clock edges after the edge that captures the first dominant input. A run of FILTER_CYC-1 dominant cycles produces no pulse.
- R3: Pattern mode: a pulse requires a dominant run of at least FILTER_CYC, then a recessive (1) run of at least FILTER_CYC, then a dominant run that reaches FILTER_CYC. The pulse is visible 3·FILTER_CYC+2 edges after the first dominant input edge when every phase is exactly FILTER_CYC long.
- R4: A dominant phase shorter than FILTER_CYC returns the detector to idle. A recessive phase shorter than FILTER_CYC restarts the sequence, and the dominant sample that ends it becomes the new first phase.
- R5: Pattern mode: the synchronised sample that completes the pattern must be no later than sample number TIMEOUT_CYC, where sample 1 is the first dominant sample. If that sample count is reached without completion, the detector drops to idle.
- R6: `wake_pulse` lasts exactly one cycle. After it, no further pulse occurs until `wake_en` goes low and then high again.
- R7: While `wake_en` is low, no pulse is issued and partial progress is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_en | input | 1 | Arms the detector while high; clears it while low |
| bus_rx_lp | input | 1 | Asynchronous low-power receiver bit, 0 = dominant |
| wake_pulse | output | 1 | One-cycle wake event |

## Verification
Two cases are hardest to reach from the ports in pattern mode. One is the completing sample landing exactly on the last allowed position of the timeout window. The other is the same pattern landing one position past it. A third delicate case is a short recessive gap that must restart the sequence rather than abort it. The bench reaches these by shrinking the filter to 4 cycles and the timeout to 16 cycles. It then sweeps the first-dominant and recessive lengths from one below the filter time up to lengths that overrun the window. Separate directed sequences place a pattern at exactly 16 and 17 samples, and insert a two-cycle recessive gap before a valid pattern.

// File: rtl/cwd_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the CAN wake-up detector.
// Assumes: nothing beyond the enums below.
package cwd_pkg;

    // Wake method selected at elaboration.
    typedef enum logic {
        WAKE_BASIC   = 1'b0,
        WAKE_PATTERN = 1'b1
    } wake_mode_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_IDLE = 3'd1,
        ST_DOM1 = 3'd2,
        ST_REC  = 3'd3,
        ST_DOM2 = 3'd4,
        ST_DONE = 3'd5
    } seq_state_e;

    // Commands from the sequencer to the timeout window counter.
    typedef enum logic [1:0] {
        TMR_HOLD  = 2'd0,
        TMR_CLR   = 2'd1,
        TMR_FIRST = 2'd2,
        TMR_INC   = 2'd3
    } tmr_cmd_e;

endpackage

// File: rtl/cwd_sync.sv
`timescale 1ns/1ps
// Module: cwd_sync
// Two-flop synchroniser for one asynchronous bit.
// Assumes: the input is a level that is stable for many clock cycles,
// so the two-cycle delay is the only effect. Reset loads RST_VAL.
module cwd_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic meta_q;
    logic sync_q;

    // Capture the asynchronous level, then resample it once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;

endmodule

// File: rtl/cwd_timeout.sv
`timescale 1ns/1ps
// Module: cwd_timeout
// Counts synchronised samples since the first dominant sample of a
// wake pattern. It flags the sample that would be number LIMIT.
// Assumes: LIMIT >= 2, and the sequencer issues FIRST on sample 1 and INC
// only while last_slot is low.
module cwd_timeout
    import cwd_pkg::*;
#(
    parameter int unsigned LIMIT = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  tmr_cmd_e cmd,
    output logic     last_slot
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(LIMIT - 1);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] cnt_q;

    // Track how many samples of the current attempt have been consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case (cmd)
                TMR_CLR:   cnt_q <= '0;
                TMR_FIRST: cnt_q <= ONE;
                TMR_INC:   cnt_q <= cnt_q + ONE;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    // The sample now being judged is cnt_q+1; flag it when it is the LIMIT-th.
    assign last_slot = (cnt_q >= LAST_IDX);

    // R5: the window counter never runs past the last permitted sample.
    a_r5_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);

endmodule

// File: rtl/cwd_seq.sv
`timescale 1ns/1ps
// Module: cwd_seq
// Phase sequencer. It qualifies dominant and recessive runs of at least
// FILTER_CYC synchronised samples, then registers a one-cycle wake pulse.
// Basic mode fires on the first qualified dominant run. Pattern mode needs
// dominant, recessive, dominant and obeys the window flag.
// Assumes: FILTER_CYC >= 2; rx_s is already synchronised; wake_en is
// synchronous to clk.
module cwd_seq
    import cwd_pkg::*;
#(
    parameter wake_mode_e  MODE       = WAKE_PATTERN,
    parameter int unsigned FILTER_CYC = 720
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wake_en,
    input  logic     rx_s,
    input  logic     last_slot,
    output tmr_cmd_e tmr_cmd,
    output logic     wake_pulse
);

    localparam int unsigned PH_W = $clog2(FILTER_CYC + 1);
    localparam logic [PH_W-1:0] F_FULL = PH_W'(FILTER_CYC);
    localparam logic [PH_W-1:0] F_LAST = PH_W'(FILTER_CYC - 1);
    localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);
    localparam bit IS_BASIC = (MODE == WAKE_BASIC);

    seq_state_e      state_q, state_d;
    logic [PH_W-1:0] ph_q, ph_d;
    logic            pulse_q;
    logic            fire;
    logic            ph_full;
    logic [PH_W-1:0] ph_inc;

    // Saturating run length of the current phase.
    assign ph_full = (ph_q >= F_FULL);
    assign ph_inc  = ph_full ? ph_q : (ph_q + PH_ONE);

    // Decide next state, run length, window command and wake firing.
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        tmr_cmd = TMR_HOLD;
        fire    = 1'b0;
        if (!wake_en) begin
            state_d = ST_OFF;
            ph_d    = '0;
            tmr_cmd = TMR_CLR;
        end else begin
            case (state_q)
                ST_OFF: begin
                    state_d = ST_IDLE;
                    ph_d    = '0;
                    tmr_cmd = TMR_CLR;
                end
                ST_IDLE: begin
                    if (!rx_s) begin
                        state_d = ST_DOM1;
                        ph_d    = PH_ONE;
                        tmr_cmd = TMR_FIRST;
                    end
                end
                ST_DOM1: begin
                    if (!rx_s) begin
                        if (IS_BASIC && (ph_q >= F_LAST)) begin
                            fire    = 1'b1;
                            state_d = ST_DONE;
                            tmr_cmd = TMR_CLR;
                        end else if (last_slot) begin
                            state_d = ST_IDLE;
                            ph_d    = '0;
                            tmr_cmd = TMR_CLR;
                        end else begin
                            ph_d    = ph_inc;
                            tmr_cmd = TMR_INC;
                        end
                    end else if (ph_full && !last_slot) begin
                        state_d = ST_REC;
                        ph_d    = PH_ONE;
                        tmr_cmd = TMR_INC;
                    end else begin
                        state_d = ST_IDLE;
                        ph_d    = '0;
                        tmr_cmd = TMR_CLR;
                    end
                end
                ST_REC: begin
                    if (rx_s) begin
                        if (last_slot) begin
                            state_d = ST_IDLE;
                            ph_d    = '0;
                            tmr_cmd = TMR_CLR;
                        end else begin
                            ph_d    = ph_inc;
                            tmr_cmd = TMR_INC;
                        end
                    end else if (!ph_full) begin
                        state_d = ST_DOM1;
                        ph_d    = PH_ONE;
                        tmr_cmd = TMR_FIRST;
                    end else if (last_slot) begin
                        state_d = ST_IDLE;
                        ph_d    = '0;
                        tmr_cmd = TMR_CLR;
                    end else begin
                        state_d = ST_DOM2;
                        ph_d    = PH_ONE;
                        tmr_cmd = TMR_INC;
                    end
                end
                ST_DOM2: begin
                    if (!rx_s) begin
                        if (ph_q >= F_LAST) begin
                            fire    = 1'b1;
                            state_d = ST_DONE;
                            tmr_cmd = TMR_CLR;
                        end else if (last_slot) begin
                            state_d = ST_IDLE;
                            ph_d    = '0;
                            tmr_cmd = TMR_CLR;
                        end else begin
                            ph_d    = ph_inc;
                            tmr_cmd = TMR_INC;
                        end
                    end else begin
                        state_d = ST_IDLE;
                        ph_d    = '0;
                        tmr_cmd = TMR_CLR;
                    end
                end
                ST_DONE: begin
                    state_d = ST_DONE;
                end
                default: begin
                    state_d = ST_OFF;
                    ph_d    = '0;
                    tmr_cmd = TMR_CLR;
                end
            endcase
        end
    end

    // Hold sequencer state and register the wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            ph_q    <= '0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            pulse_q <= fire;
        end
    end

    assign wake_pulse = pulse_q;

    // R4: the run length never exceeds its saturation value.
    a_r4_phase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q <= F_FULL);

    // R6: a pulse lasts a single cycle.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);

    // R6: a pulse is only seen once the sequencer has gone inert.
    a_r6_pulse_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (state_q == ST_DONE));

    // R6: the inert state persists while the enable stays high.
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DONE) && wake_en) |=> (state_q == ST_DONE));

    // R7: a low enable clears progress and suppresses the pulse.
    a_r7_disabled_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_en |=> ((state_q == ST_OFF) && !pulse_q));

endmodule

// File: rtl/can_wake_detect.sv
`timescale 1ns/1ps
// Module: can_wake_detect
// Top of the CAN bus wake-up detector. The flow is: synchroniser, then
// phase sequencer, then (pattern mode only) the timeout window counter.
// Assumes: FILTER_CYC >= 2; TIMEOUT_CYC >= 2; bus_rx_lp is 0 when the bus
// is dominant; wake_en is synchronous to clk.
module can_wake_detect
    import cwd_pkg::*;
#(
    parameter wake_mode_e  MODE          = WAKE_PATTERN,
    parameter int unsigned CLK_PERIOD_PS = 5000,
    parameter int unsigned FILTER_CYC    = 3_600_000 / CLK_PERIOD_PS,
    parameter int unsigned TIMEOUT_CYC   = 200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_en,
    input  logic bus_rx_lp,
    output logic wake_pulse
);

    logic     rx_s;
    logic     last_slot;
    tmr_cmd_e tmr_cmd;

    cwd_sync #(
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (bus_rx_lp),
        .q_sync  (rx_s)
    );

    cwd_seq #(
        .MODE       (MODE),
        .FILTER_CYC (FILTER_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_en    (wake_en),
        .rx_s       (rx_s),
        .last_slot  (last_slot),
        .tmr_cmd    (tmr_cmd),
        .wake_pulse (wake_pulse)
    );

    // The window counter exists only when the three-phase method is built.
    generate
        if (MODE == WAKE_PATTERN) begin : g_window
            cwd_timeout #(
                .LIMIT (TIMEOUT_CYC)
            ) u_window (
                .clk       (clk),
                .rst_n     (rst_n),
                .cmd       (tmr_cmd),
                .last_slot (last_slot)
            );
        end else begin : g_no_window
            assign last_slot = 1'b0;
        end
    endgenerate

    // R1: no pulse in the cycle right after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !wake_pulse);

endmodule

// File: tb/can_wake_detect_bench.sv
`timescale 1ns/1ps
// Bench: drives both wake methods with shrunken timing and sweeps phase
// lengths around the filter and timeout limits.
module can_wake_detect_bench;
    import cwd_pkg::*;

    localparam int F = 4;
    localparam int T = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake_en = 1'b0;
    logic rx = 1'b1;
    logic wake_p;
    logic wake_b;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int pcount_p = 0;
    int pcount_b = 0;
    int last_p = -1;
    int last_b = -1;

    always #2.5 clk = ~clk;

    can_wake_detect #(
        .MODE        (WAKE_PATTERN),
        .FILTER_CYC  (F),
        .TIMEOUT_CYC (T)
    ) u_can_wake_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_en    (wake_en),
        .bus_rx_lp  (rx),
        .wake_pulse (wake_p)
    );

    can_wake_detect #(
        .MODE        (WAKE_BASIC),
        .FILTER_CYC  (F),
        .TIMEOUT_CYC (T)
    ) u_can_wake_detect_basic (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_en    (wake_en),
        .bus_rx_lp  (rx),
        .wake_pulse (wake_b)
    );

    // Count cycles and pulse cycles away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (wake_p) begin
            pcount_p = pcount_p + 1;
            last_p = cyc;
        end
        if (wake_b) begin
            pcount_b = pcount_b + 1;
            last_b = cyc;
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        rx = lvl;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic rearm();
        wake_en = 1'b0;
        hold(1'b1, 2);
        wake_en = 1'b1;
        hold(1'b1, 3);
    endtask

    task automatic trial(input string req, input int d1, input int r, input int d2, input int exp);
        int p0;
        rearm();
        p0 = pcount_p;
        hold(1'b0, d1);
        hold(1'b1, r);
        hold(1'b0, d2);
        hold(1'b1, T + 8);
        check_eq(req, $sformatf("pattern d1=%0d r=%0d d2=%0d", d1, r, d2), pcount_p - p0, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0;
        int p0;
        int b0;
        int exp;

        // R1: reset with a dominant bus and the enable high.
        rx = 1'b0;
        wake_en = 1'b1;
        rst_n = 1'b0;
        hold(1'b0, 8);
        check_eq("R1", "pattern pulse in reset", int'(wake_p), 0);
        check_eq("R1", "basic pulse in reset", int'(wake_b), 0);
        hold(1'b1, 3);
        rst_n = 1'b1;
        hold(1'b1, 12);
        check_eq("R1", "pulses after reset", pcount_p + pcount_b, 0);

        // R2: basic mode latency, then one pulse only over a long dominant run (R6).
        rearm();
        c0 = cyc;
        b0 = pcount_b;
        p0 = pcount_p;
        hold(1'b0, F + 20);
        check_eq("R2", "basic pulse count", pcount_b - b0, 1);
        check_eq("R2", "basic pulse cycle", last_b, c0 + F + 2);
        check_eq("R6", "basic single pulse in long dominant", pcount_b - b0, 1);
        check_eq("R5", "pattern no wake on steady dominant", pcount_p - p0, 0);
        hold(1'b1, T + 4);

        // R2: dominant one cycle short of the filter.
        rearm();
        b0 = pcount_b;
        hold(1'b0, F - 1);
        hold(1'b1, 12);
        check_eq("R2", "basic short dominant", pcount_b - b0, 0);

        // R7: basic detector disabled during a long dominant run.
        wake_en = 1'b0;
        b0 = pcount_b;
        hold(1'b0, F + 6);
        hold(1'b1, 6);
        check_eq("R7", "basic while disabled", pcount_b - b0, 0);
        wake_en = 1'b1;
        hold(1'b1, 3);

        // R3: exact-length pattern and its latency.
        rearm();
        c0 = cyc;
        p0 = pcount_p;
        hold(1'b0, F);
        hold(1'b1, F);
        hold(1'b0, F);
        hold(1'b1, 10);
        check_eq("R3", "pattern pulse count", pcount_p - p0, 1);
        check_eq("R3", "pattern pulse cycle", last_p, c0 + 3 * F + 2);

        // R3, R4, R5: sweep of phase lengths around filter and window.
        for (int d1 = F - 1; d1 <= F + 3; d1++) begin
            for (int r = F - 1; r <= F + 3; r++) begin
                for (int d2 = F - 1; d2 <= F; d2++) begin
                    exp = (d1 >= F && r >= F && d2 >= F && (d1 + r + F) <= T) ? 1 : 0;
                    trial("R3/R4/R5 sweep", d1, r, d2, exp);
                end
            end
        end

        // R5: completion on the last allowed sample and one past it.
        trial("R5", F, T - 2 * F, F, 1);
        trial("R5", F, T - 2 * F + 1, F, 0);
        trial("R5", T - 2 * F, F, F, 1);
        trial("R5", T - 2 * F + 1, F, F, 0);

        // R4: a short recessive gap restarts the sequence.
        rearm();
        p0 = pcount_p;
        hold(1'b0, F);
        hold(1'b1, 2);
        hold(1'b0, F);
        hold(1'b1, F);
        hold(1'b0, F);
        hold(1'b1, T + 8);
        check_eq("R4", "restart after short recessive", pcount_p - p0, 1);

        // R4: a short recessive then no fresh pattern gives nothing.
        rearm();
        p0 = pcount_p;
        hold(1'b0, F);
        hold(1'b1, F - 1);
        hold(1'b0, F);
        hold(1'b1, T + 8);
        check_eq("R4", "short recessive aborts", pcount_p - p0, 0);

        // R6: inert after a pulse until the enable is toggled.
        rearm();
        p0 = pcount_p;
        hold(1'b0, F);
        hold(1'b1, F);
        hold(1'b0, F);
        hold(1'b1, T);
        hold(1'b0, F);
        hold(1'b1, F);
        hold(1'b0, F);
        hold(1'b1, T);
        check_eq("R6", "second pattern while inert", pcount_p - p0, 1);
        rearm();
        hold(1'b0, F);
        hold(1'b1, F);
        hold(1'b0, F);
        hold(1'b1, T);
        check_eq("R6", "pattern after re-enable", pcount_p - p0, 2);

        // R7: enable dropped mid-pattern discards the first dominant phase.
        rearm();
        p0 = pcount_p;
        hold(1'b0, F);
        wake_en = 1'b0;
        hold(1'b0, 1);
        wake_en = 1'b1;
        hold(1'b1, F);
        hold(1'b0, F);
        hold(1'b1, T + 8);
        check_eq("R7", "progress cleared by disable", pcount_p - p0, 0);

        // R7: full pattern while disabled.
        wake_en = 1'b0;
        p0 = pcount_p;
        hold(1'b0, F);
        hold(1'b1, F);
        hold(1'b0, F);
        hold(1'b1, T);
        check_eq("R7", "pattern while disabled", pcount_p - p0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule